// File: doc/BRIEF.md
# Stackless Highest-Priority Interrupt Sequencer

This block runs the entry sequence for the top-priority interrupt of a small 16-bit processor. It does not use the stack or the status register. It waits for a request at an instruction boundary while its private arm flag is set. It then fetches a pointer word from a fixed low address and stores the interrupted program counter at the address that word names. Last, it steers the program counter to a fixed vector address.

While the routine runs, the block keeps further top-level requests out. It also holds off acceptance of the lower interrupt levels through a gate output. Software reopens both by issuing a set-flag or pulse-flag operation that names the re-arm pseudo-bit. The block only drives a simple synchronous memory port (one read, one write), a program-counter load, a busy line and the lower-level gate. The stack, the accumulators and the flag register are never touched, so the sequence cannot overflow the stack.

Top module: `pcsave_trap_seq`

## Requirements
- R1: After reset, busy, mem_rd, mem_wr and pc_load are 0, and low_irq_en is 1 (the block is armed).
- R2: A request is accepted on a clock edge where irq_req, insn_boundary and the arm flag are all 1 and the block is idle. In the cycle after that edge, mem_rd is 1 and mem_addr is 0x0007.
- R3: Read data returns one cycle after mem_rd. Two cycles after the read, mem_wr is 1 for one cycle, mem_addr equals the word read from 0x0007, and mem_wdata equals the pc_in value sampled at the accepting edge.
- R4: In the cycle after the write, pc_load is 1 for exactly one cycle with pc_value = 0x0008.
- R5: busy is 1 in exactly the four cycles from the read to the program-counter load, and 0 in the cycle after.
- R6: Acceptance clears the arm flag. Until re-arm, further requests cause no memory access and no busy.
- R7: flag_op with flag_idx = 15 re-arms the block. flag_op with any other index has no effect.
- R8: low_irq_en falls in the cycle after acceptance, stays 0 until the re-arm strobe, and rises in the cycle after it.
- R9: A request without insn_boundary is ignored, and a dropped request is not remembered.
- R10: If acceptance and a re-arm strobe share an edge, acceptance wins and the block stays disarmed.
- R11: mem_rd and mem_wr are never 1 together. Each sequence makes one read and one write and nothing else.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 1 | Top-level interrupt request (level) |
| insn_boundary | input | 1 | High when the core is between instructions |
| pc_in | input | 16 | Current program counter |
| flag_op | input | 1 | Set-flag or pulse-flag operation strobe |
| flag_idx | input | 4 | Flag bit index named by the operation |
| mem_rdata | input | 16 | Read data, valid one cycle after mem_rd |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| pc_load | output | 1 | Program counter load pulse |
| pc_value | output | 16 | Value to load into the program counter |
| busy | output | 1 | Sequence in progress |
| low_irq_en | output | 1 | Permits acceptance of lower interrupt levels |

## Verification
Counting from the accepting edge, the read appears 1 cycle later, the write 3 cycles later and the program-counter load 4 cycles later. busy drops 5 cycles after that edge. low_irq_en changes 1 cycle after acceptance or after the re-arm strobe. The bench drives inputs on falling edges and checks each output on the falling edge of the cycle in which it is due. Each sequence is walked cycle by cycle, so an early, late or stretched strobe is caught in that exact cycle.

// File: rtl/pcsave_pkg.sv
package pcsave_pkg;
   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_READ_PTR = 3'd1,
      ST_WAIT_PTR = 3'd2,
      ST_WRITE_PC = 3'd3,
      ST_LOAD_VEC = 3'd4
   } seq_state_t;
endpackage

// File: rtl/pcsave_arm.sv
module pcsave_arm #(
   parameter int IDX_W     = 4,
   parameter int REARM_BIT = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept_i,
   input  logic             flag_op_i,
   input  logic [IDX_W-1:0] flag_idx_i,
   output logic             armed_o,
   output logic             low_en_o
);
   localparam logic [IDX_W-1:0] REARM_IDX = IDX_W'(REARM_BIT);

   generate
      if (REARM_BIT >= (1 << IDX_W)) begin : g_bad_idx
         $error("REARM_BIT does not fit in IDX_W bits");
      end
   endgenerate

   logic rearm;
   assign rearm = flag_op_i && (flag_idx_i == REARM_IDX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_o  <= 1'b1;
         low_en_o <= 1'b1;
      end else if (accept_i) begin
         armed_o  <= 1'b0;
         low_en_o <= 1'b0;
      end else if (rearm) begin
         armed_o  <= 1'b1;
         low_en_o <= 1'b1;
      end
   end

   // R6: once disarmed, only a re-arm strobe sets the flag again
   p_stay_disarmed_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed_o && !rearm) |=> !armed_o);
   // R10: acceptance beats a same-edge re-arm
   p_accept_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (accept_i && rearm) |=> !armed_o);
   // R7: re-arm strobe without acceptance opens the level
   p_rearm_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rearm && !accept_i) |=> armed_o);
   // R8: the lower-level gate follows acceptance
   p_low_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      accept_i |=> !low_en_o);
endmodule

// File: rtl/pcsave_fsm.sv
module pcsave_fsm
   import pcsave_pkg::*;
#(
   parameter int              ADDR_W        = 16,
   parameter int              DATA_W        = 16,
   parameter logic [ADDR_W-1:0] PTR_ADDR    = 16'h0007,
   parameter logic [ADDR_W-1:0] VEC_ADDR    = 16'h0008,
   parameter bit              IDLE_ZERO_BUS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] pc_i,
   input  logic [DATA_W-1:0] mem_rdata_i,
   output logic              mem_rd_o,
   output logic              mem_wr_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   output logic              pc_load_o,
   output logic [ADDR_W-1:0] pc_value_o,
   output logic              busy_o,
   output logic              idle_o
);
   generate
      if (DATA_W < ADDR_W) begin : g_bad_width
         $error("DATA_W must hold a full address");
      end
   endgenerate

   seq_state_t        state, nxt;
   logic [ADDR_W-1:0] ptr_q;
   logic [ADDR_W-1:0] pc_q;

   always_comb begin
      nxt = state;
      case (state)
         ST_IDLE:     if (start_i) nxt = ST_READ_PTR;
         ST_READ_PTR: nxt = ST_WAIT_PTR;
         ST_WAIT_PTR: nxt = ST_WRITE_PC;
         ST_WRITE_PC: nxt = ST_LOAD_VEC;
         ST_LOAD_VEC: nxt = ST_IDLE;
         default:     nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         ptr_q <= '0;
         pc_q  <= '0;
      end else begin
         state <= nxt;
         if (start_i && state == ST_IDLE) pc_q <= pc_i;
         if (state == ST_WAIT_PTR) ptr_q <= mem_rdata_i[ADDR_W-1:0];
      end
   end

   assign mem_rd_o   = (state == ST_READ_PTR);
   assign mem_wr_o   = (state == ST_WRITE_PC);
   assign pc_load_o  = (state == ST_LOAD_VEC);
   assign pc_value_o = pc_load_o ? VEC_ADDR : '0;
   assign busy_o     = (state != ST_IDLE);
   assign idle_o     = (state == ST_IDLE);

   generate
      if (IDLE_ZERO_BUS) begin : g_zero_bus
         assign mem_addr_o  = mem_rd_o ? PTR_ADDR : (mem_wr_o ? ptr_q : '0);
         assign mem_wdata_o = mem_wr_o ? DATA_W'(pc_q) : '0;
      end else begin : g_hold_bus
         assign mem_addr_o  = mem_rd_o ? PTR_ADDR : ptr_q;
         assign mem_wdata_o = DATA_W'(pc_q);
      end
   endgenerate

   // R2: the pointer fetch follows acceptance by one cycle
   p_fetch_ptr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (mem_rd_o && mem_addr_o == PTR_ADDR));
   // R3: the store comes two cycles after the fetch
   p_store_pc_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_o |-> ##2 mem_wr_o);
   // R4: the vector load is a single-cycle pulse following the store
   p_load_after_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_o |=> (pc_load_o && pc_value_o == VEC_ADDR));
   p_load_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load_o |=> !pc_load_o);
   // R5: busy ends right after the load
   p_busy_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load_o |=> !busy_o);
   // R11: never read and write together
   p_one_access_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd_o && mem_wr_o));
   // R2: a start is only offered while idle
   p_start_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> idle_o);
endmodule

// File: rtl/pcsave_trap_seq.sv
module pcsave_trap_seq #(
   parameter int                ADDR_W        = 16,
   parameter int                DATA_W        = 16,
   parameter int                IDX_W         = 4,
   parameter int                REARM_BIT     = 15,
   parameter logic [ADDR_W-1:0] PTR_ADDR      = 16'h0007,
   parameter logic [ADDR_W-1:0] VEC_ADDR      = 16'h0008,
   parameter bit                IDLE_ZERO_BUS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              irq_req,
   input  logic              insn_boundary,
   input  logic [ADDR_W-1:0] pc_in,
   input  logic              flag_op,
   input  logic [IDX_W-1:0]  flag_idx,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              pc_load,
   output logic [ADDR_W-1:0] pc_value,
   output logic              busy,
   output logic              low_irq_en
);
   logic armed;
   logic idle;
   logic accept;

   assign accept = irq_req && insn_boundary && armed && idle;

   pcsave_arm #(
      .IDX_W     (IDX_W),
      .REARM_BIT (REARM_BIT)
   ) u_arm (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept_i   (accept),
      .flag_op_i  (flag_op),
      .flag_idx_i (flag_idx),
      .armed_o    (armed),
      .low_en_o   (low_irq_en)
   );

   pcsave_fsm #(
      .ADDR_W        (ADDR_W),
      .DATA_W        (DATA_W),
      .PTR_ADDR      (PTR_ADDR),
      .VEC_ADDR      (VEC_ADDR),
      .IDLE_ZERO_BUS (IDLE_ZERO_BUS)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (accept),
      .pc_i        (pc_in),
      .mem_rdata_i (mem_rdata),
      .mem_rd_o    (mem_rd),
      .mem_wr_o    (mem_wr),
      .mem_addr_o  (mem_addr),
      .mem_wdata_o (mem_wdata),
      .pc_load_o   (pc_load),
      .pc_value_o  (pc_value),
      .busy_o      (busy),
      .idle_o      (idle)
   );

   // R9: no boundary, no sequence start
   p_need_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && !insn_boundary) |=> !busy);
   // R8: the lower-level gate stays shut while a sequence runs
   p_gate_during_seq_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !flag_op) |-> !low_irq_en);
endmodule

// File: tb/tb_pcsave_trap_seq.sv
`timescale 1ns/1ps
module tb_pcsave_trap_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        irq_req = 1'b0;
   logic        insn_boundary = 1'b0;
   logic [15:0] pc_in = '0;
   logic        flag_op = 1'b0;
   logic [3:0]  flag_idx = '0;
   logic [15:0] mem_rdata = '0;
   logic        mem_rd, mem_wr, pc_load, busy, low_irq_en;
   logic [15:0] mem_addr, mem_wdata, pc_value;

   logic [15:0] ptr_word = 16'hFF00;
   int          n_chk = 0;
   int          n_bad = 0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;

   pcsave_trap_seq dut (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .insn_boundary(insn_boundary),
      .pc_in(pc_in), .flag_op(flag_op), .flag_idx(flag_idx), .mem_rdata(mem_rdata),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .pc_load(pc_load), .pc_value(pc_value), .busy(busy), .low_irq_en(low_irq_en)
   );

   // memory model: one-cycle read latency, only the pointer cell is meaningful
   always @(posedge clk) begin
      if (mem_rd) mem_rdata <= (mem_addr == 16'h0007) ? ptr_word : 16'hDEAD;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rearm(input logic [3:0] idx);
      @(negedge clk);
      flag_op  = 1'b1;
      flag_idx = idx;
      @(negedge clk);
      flag_op  = 1'b0;
   endtask

   // drive an accepted request and walk the sequence cycle by cycle
   task automatic run_seq(input logic [15:0] pc, input logic [15:0] ptr, input bit with_rearm);
      ptr_word = ptr;
      @(negedge clk);
      irq_req = 1'b1; insn_boundary = 1'b1; pc_in = pc;
      if (with_rearm) begin flag_op = 1'b1; flag_idx = 4'd15; end
      @(negedge clk);
      irq_req = 1'b0; insn_boundary = 1'b0; pc_in = ~pc; flag_op = 1'b0;
      chk("R2 read strobe", mem_rd, 1);
      chk("R2 read addr", mem_addr, 16'h0007);
      chk("R5 busy read", busy, 1);
      chk("R8 gate low", low_irq_en, 0);
      @(negedge clk);
      chk("R11 idle in wait", {mem_rd, mem_wr}, 0);
      chk("R5 busy wait", busy, 1);
      @(negedge clk);
      chk("R3 write strobe", mem_wr, 1);
      chk("R3 write addr", mem_addr, ptr);
      chk("R3 write data", mem_wdata, pc);
      chk("R11 no read with write", mem_rd, 0);
      @(negedge clk);
      chk("R4 load pulse", pc_load, 1);
      chk("R4 load value", pc_value, 16'h0008);
      chk("R5 busy load", busy, 1);
      chk("R11 no access in load", {mem_rd, mem_wr}, 0);
      @(negedge clk);
      chk("R4 single pulse", pc_load, 0);
      chk("R5 busy ends", busy, 0);
   endtask

   // hold a request for n cycles and expect no response
   task automatic expect_ignored(input string req, input bit bnd, input int n);
      @(negedge clk);
      irq_req = 1'b1; insn_boundary = bnd;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         chk(req, {busy, mem_rd, mem_wr}, 0);
      end
      irq_req = 1'b0; insn_boundary = 1'b0;
   endtask

   localparam int NV = 4;
   localparam logic [31:0] VEC [NV] = '{
      {16'h1234, 16'hFF00},
      {16'hFFFF, 16'h0000},
      {16'h0000, 16'hFFFF},
      {16'hA5C3, 16'h0100}
   };

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset busy", busy, 0);
      chk("R1 reset strobes", {mem_rd, mem_wr, pc_load}, 0);
      chk("R1 reset gate", low_irq_en, 1);

      for (int i = 0; i < NV; i++) begin
         run_seq(VEC[i][31:16], VEC[i][15:0], 1'b0);
         chk("R8 gate held", low_irq_en, 0);
         rearm(4'd15);
         chk("R8 gate reopens", low_irq_en, 1);
      end

      // R6: disarmed after a sequence
      run_seq(16'h4321, 16'h2000, 1'b0);
      expect_ignored("R6 disarmed ignores", 1'b1, 3);
      // R7: wrong index does nothing
      rearm(4'd14);
      chk("R7 wrong index gate", low_irq_en, 0);
      expect_ignored("R7 wrong index stays disarmed", 1'b1, 2);
      rearm(4'd15);
      chk("R7 rearm gate", low_irq_en, 1);

      // R9: no boundary, then boundary without request
      expect_ignored("R9 no boundary", 1'b0, 3);
      @(negedge clk);
      insn_boundary = 1'b1;
      @(negedge clk);
      chk("R9 not latched", busy, 0);
      insn_boundary = 1'b0;

      // R10: accept and re-arm on one edge
      run_seq(16'h7777, 16'h3000, 1'b1);
      chk("R10 gate stays low", low_irq_en, 0);
      expect_ignored("R10 accept wins", 1'b1, 2);
      rearm(4'd15);
      run_seq(16'h0102, 16'hFF00, 1'b0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=running expected=done");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule